// File: doc/BRIEF.md
# Johnson-Encoded Decade Counter Decoder

This block divides a slow count trigger by ten. The count state is a five-stage Johnson (twisted-ring) shift register. Its ten states are decoded into ten one-hot outputs, so exactly one output is high at any time, and each output stays high for one count period. A terminal-count output is high during the first half of the ten-state cycle. It rises as the last decoded output falls, so several stages can be chained.

All logic runs on one system clock. The count trigger (`count_clk`), the hold input (`hold_in`) and the master clear (`clear_in`) come in asynchronously. Each passes through a two-flop synchronizer. Edges are then found by comparing the current and previous synchronized samples. A rising `count_clk` advances the counter while `hold_in` is low. A falling `hold_in` also advances it while `count_clk` is high, so the hold input can serve as an inverted alternate trigger. `clear_in` forces state zero and wins over everything else. The Johnson register also repairs itself: any pattern that is not one of the ten legal codes is replaced by the state-zero code on the next system clock.

Top module: `decade_ring_divider`

## Requirements
- R1: While `rst_n` is low and after it is released, with no trigger edge applied, `dec_out` equals 10'b00_0000_0001 (bit 0 high) and `term_cnt` is 1.
- R2: Each qualifying advance moves the single high bit of `dec_out` from bit i to bit i+1, and from bit 9 back to bit 0. Exactly one bit of `dec_out` is high in every cycle.
- R3: A rising edge on `count_clk` while `hold_in` is low advances the count by one state.
- R4: A falling edge on `hold_in` while `count_clk` is high advances the count by one state.
- R5: A rising `count_clk` while `hold_in` is high does not advance the count. A falling `count_clk` never advances it, and neither does a rising `hold_in`.
- R6: While `clear_in` is high, `dec_out` is bit 0 only and `term_cnt` is 1. Trigger edges that arrive during that time are ignored.
- R7: `term_cnt` is 1 when bit 0, 1, 2, 3 or 4 of `dec_out` is high, and 0 when bit 5 to 9 is high.
- R8: After an input changes on a system-clock falling edge, `dec_out` and `term_cnt` still show the old state after three rising edges and show the new state after the fourth.
- R9: A rising `count_clk` and a falling `hold_in` seen in the same system cycle advance the count by exactly one state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| count_clk | input | 1 | Asynchronous count trigger; rising edge advances |
| hold_in | input | 1 | Asynchronous hold; high blocks advances, its falling edge advances while `count_clk` is high |
| clear_in | input | 1 | Asynchronous master clear, active high |
| dec_out | output | 10 | One-hot decoded state, bit i high in state i |
| term_cnt | output | 1 | High in states 0 to 4 |

## Verification
A run of ten `count_clk` pulses walks through every state and the wrap back to zero, with `term_cnt` checked in each state. This confirms both the decode and the half-cycle terminal count. Separate patterns test the edge rules one at a time: a rising trigger while held, a falling trigger, and a rising hold must all leave the state alone. A falling hold while the trigger is high must advance it, and both edges arriving together must advance it by one step only. The clear input is checked for priority over trigger pulses sent while it is high. The pipeline depth is confirmed by sampling just before and just after the fourth clock edge.

// File: rtl/decade_ring_pkg.sv
package decade_ring_pkg;
  localparam int unsigned DEF_RING_STAGES = 5;
  localparam int unsigned DEF_SYNC_DEPTH  = 2;

  typedef struct packed {
    logic clear;
    logic hold;
    logic trig;
  } trig_bus_t;
endpackage

// File: rtl/ring_sync.sv
module ring_sync #(
  parameter int unsigned WIDTH = 3,
  parameter int unsigned DEPTH = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [DEPTH-1:0][WIDTH-1:0] pipe_q;
  logic [DEPTH-1:0][WIDTH-1:0] pipe_d;

  always_comb begin
    pipe_d[0] = async_i;
    for (int i = 1; i < DEPTH; i++) pipe_d[i] = pipe_q[i-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= '0;
    else        pipe_q <= pipe_d;
  end

  assign sync_o = pipe_q[DEPTH-1];
endmodule

// File: rtl/ring_trigger.sv
module ring_trigger (
  input  logic clk,
  input  logic rst_n,
  input  logic trig_s,
  input  logic hold_s,
  output logic step_o
);
  logic trig_prev_q, hold_prev_q;
  logic trig_rise, trig_fall, hold_fall;

  always_comb begin
    trig_rise = trig_s & ~trig_prev_q;
    trig_fall = ~trig_s & trig_prev_q;
    hold_fall = ~hold_s & hold_prev_q;
    // Either cause, or both together, gives one step.
    step_o = (trig_rise & ~hold_s) | (hold_fall & trig_s);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trig_prev_q <= 1'b0;
      hold_prev_q <= 1'b0;
    end else begin
      trig_prev_q <= trig_s;
      hold_prev_q <= hold_s;
    end
  end

  AST_NO_FALL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_fall && !hold_fall) |-> !step_o); // R5
  AST_HELD_NO_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_s && hold_prev_q) |-> !step_o); // R5
endmodule

// File: rtl/ring_core.sv
module ring_core #(
  parameter int unsigned STAGES = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear_i,
  input  logic              step_i,
  output logic [STAGES-1:0] ring_o
);
  logic [STAGES-1:0] ring_q, ring_d, ring_shift;
  logic              ring_legal;

  function automatic logic is_legal(input logic [STAGES-1:0] v);
    int unsigned flips;
    flips = 0;
    for (int i = 0; i < STAGES - 1; i++) flips += (v[i] ^ v[i+1]) ? 1 : 0;
    return flips <= 1;
  endfunction

  always_comb begin
    ring_legal = is_legal(ring_q);
    ring_shift = {ring_q[STAGES-2:0], ~ring_q[STAGES-1]};
    ring_d     = ring_q;
    if (clear_i || !ring_legal) ring_d = '0;
    else if (step_i)            ring_d = ring_shift;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ring_q <= '0;
    else        ring_q <= ring_d;
  end

  assign ring_o = ring_q;

  AST_LEGAL_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    ring_legal); // R2
  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |=> (ring_q == '0)); // R6
  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!step_i && !clear_i) |=> $stable(ring_q)); // R5
endmodule

// File: rtl/ring_decode.sv
module ring_decode #(
  parameter int unsigned STAGES = 5,
  localparam int unsigned NOUT = 2 * STAGES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [STAGES-1:0] ring_i,
  output logic [NOUT-1:0]   dec_o,
  output logic              tc_o
);
  logic [NOUT-1:0] dec_d, dec_q;
  logic            tc_d, tc_q;

  assign dec_d[0]      = ~ring_i[STAGES-1] & ~ring_i[0];
  assign dec_d[STAGES] =  ring_i[STAGES-1] &  ring_i[0];

  genvar k;
  generate
    for (k = 1; k < STAGES; k++) begin : g_pair
      assign dec_d[k]          =  ring_i[k-1] & ~ring_i[k];
      assign dec_d[STAGES + k] = ~ring_i[k-1] &  ring_i[k];
    end
  endgenerate

  assign tc_d = ~ring_i[STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dec_q <= NOUT'(1);
      tc_q  <= 1'b1;
    end else begin
      dec_q <= dec_d;
      tc_q  <= tc_d;
    end
  end

  assign dec_o = dec_q;
  assign tc_o  = tc_q;

  AST_ONE_HOT: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(dec_q) == 1); // R2
  AST_TC_HALF: assert property (@(posedge clk) disable iff (!rst_n)
    tc_q == (|dec_q[STAGES-1:0])); // R7
endmodule

// File: rtl/decade_ring_divider.sv
module decade_ring_divider
  import decade_ring_pkg::*;
#(
  parameter int unsigned RING_STAGES = DEF_RING_STAGES,
  parameter int unsigned SYNC_DEPTH  = DEF_SYNC_DEPTH,
  localparam int unsigned NOUT = 2 * RING_STAGES
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            count_clk,
  input  logic            hold_in,
  input  logic            clear_in,
  output logic [NOUT-1:0] dec_out,
  output logic            term_cnt
);
  logic [1:0]             rst_pipe_q;
  logic                   rst_int_n;
  trig_bus_t              raw_bus, sync_bus;
  logic                   step;
  logic [RING_STAGES-1:0] ring;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_int_n = rst_pipe_q[1];

  assign raw_bus = '{clear: clear_in, hold: hold_in, trig: count_clk};

  ring_sync #(.WIDTH($bits(trig_bus_t)), .DEPTH(SYNC_DEPTH)) u_sync (
    .clk(clk), .rst_n(rst_int_n), .async_i(raw_bus), .sync_o(sync_bus));

  ring_trigger u_trig (
    .clk(clk), .rst_n(rst_int_n), .trig_s(sync_bus.trig),
    .hold_s(sync_bus.hold), .step_o(step));

  ring_core #(.STAGES(RING_STAGES)) u_core (
    .clk(clk), .rst_n(rst_int_n), .clear_i(sync_bus.clear),
    .step_i(step), .ring_o(ring));

  ring_decode #(.STAGES(RING_STAGES)) u_dec (
    .clk(clk), .rst_n(rst_int_n), .ring_i(ring),
    .dec_o(dec_out), .tc_o(term_cnt));
endmodule

// File: tb/decade_ring_divider_tb_top.sv
module decade_ring_divider_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_n, count_clk, hold_in, clear_in;
  logic [9:0] dec_out;
  logic       term_cnt;
  int         checks = 0, errors = 0, idx = 0;
  bit         done = 0;

  always #2.5 clk_i = ~clk_i;

  decade_ring_divider dut_i (
    .clk(clk_i), .rst_n(rst_n), .count_clk(count_clk), .hold_in(hold_in),
    .clear_in(clear_in), .dec_out(dec_out), .term_cnt(term_cnt));

  task automatic wait_cyc(input int n);
    repeat (n) @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic check_state(input string req, input int exp_idx);
    logic [9:0] exp_dec;
    logic       exp_tc;
    exp_dec = 10'(1) << exp_idx;
    exp_tc  = (exp_idx < 5);
    checks++;
    if (dec_out !== exp_dec || term_cnt !== exp_tc) begin
      errors++;
      $display("FAIL %s: dec_out=%b term_cnt=%b expected dec_out=%b term_cnt=%b",
               req, dec_out, term_cnt, exp_dec, exp_tc);
    end
  endtask

  task automatic trig_pulse();
    count_clk = 1'b1; wait_cyc(6);
    count_clk = 1'b0; wait_cyc(6);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; count_clk = 1'b0; hold_in = 1'b0; clear_in = 1'b0;
    wait_cyc(3);
    check_state("R1 during reset", 0);
    rst_n = 1'b1; wait_cyc(8);
    check_state("R1 after release", 0);
    idx = 0;
  endtask

  task automatic t_sequence();
    for (int n = 0; n < 10; n++) begin
      trig_pulse();
      idx = (idx + 1) % 10;
      check_state("R2 R3 R7 step", idx);
    end
  endtask

  task automatic t_latency();
    count_clk = 1'b1;
    wait_cyc(3);
    check_state("R8 old state after 3 edges", idx);
    wait_cyc(1);
    idx = (idx + 1) % 10;
    check_state("R8 new state after 4th edge", idx);
    wait_cyc(4);
    count_clk = 1'b0; wait_cyc(6);
    check_state("R5 falling trigger ignored", idx);
  endtask

  task automatic t_hold_block();
    hold_in = 1'b1; wait_cyc(6);
    check_state("R5 rising hold ignored", idx);
    count_clk = 1'b1; wait_cyc(6);
    check_state("R5 trigger rise while held", idx);
    hold_in = 1'b0; wait_cyc(6);
    idx = (idx + 1) % 10;
    check_state("R4 falling hold with trigger high", idx);
    count_clk = 1'b0; wait_cyc(6);
    check_state("R5 trigger fall after alt step", idx);
  endtask

  task automatic t_coincident();
    hold_in = 1'b1; wait_cyc(6);
    count_clk = 1'b1; hold_in = 1'b0; wait_cyc(8);
    idx = (idx + 1) % 10;
    check_state("R9 both edges one step", idx);
    hold_in = 1'b1; wait_cyc(6);
    count_clk = 1'b0; wait_cyc(6);
    hold_in = 1'b0; wait_cyc(6);
    check_state("R5 release sequence no step", idx);
  endtask

  task automatic t_clear();
    trig_pulse(); idx = (idx + 1) % 10;
    trig_pulse(); idx = (idx + 1) % 10;
    check_state("R3 pre-clear steps", idx);
    clear_in = 1'b1; wait_cyc(6);
    idx = 0;
    check_state("R6 clear forces state 0", idx);
    trig_pulse(); trig_pulse();
    check_state("R6 trigger ignored during clear", idx);
    clear_in = 1'b0; wait_cyc(6);
    check_state("R6 after clear release", idx);
    trig_pulse(); idx = 1;
    check_state("R6 R3 counting resumes", idx);
  endtask

  initial begin
    t_reset();
    t_sequence();
    t_latency();
    t_hold_block();
    t_coincident();
    t_clear();
    t_sequence();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk_i);
        checks++; errors++;
        $display("FAIL watchdog: run not finished, expected completion");
      end
    join_any
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule